// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transmitter

This block sends bytes as asynchronous serial frames on one output line. Software pushes bytes into a 16-entry queue. While transmit enable is high, the frame engine pulls bytes from the queue one at a time. For each byte it sends a start bit, seven or eight data bits, an optional extra bit and one or two stop bits. The line stays at 1 whenever no frame is on it. The engine checks the queue when the first stop bit begins. If a byte is waiting, the next frame follows the last stop bit with no idle gap.

Three outputs report progress. A low-water flag fires when the queue level is at or below a programmable trigger level. An end flag fires when a frame finishes and nothing is queued behind it. An interrupt request follows the low-water flag while transmission is enabled. Bit timing comes from an external baud tick pulse, and each bit lasts a fixed number of ticks.

Top module: `sertx_top`

## Requirements
- R1: Each frame is a 0 start bit, then the data bits, then the optional extra bit, then one stop bit (two_stop_i=0) or two stop bits (two_stop_i=1), all at 1. The frame's settings are captured when its byte leaves the queue.
- R2: len7_i=1 sends bits [6:0] of the byte and len7_i=0 sends all 8 bits. msb_first_i=0 sends the lowest bit first and msb_first_i=1 sends the highest sent bit first.
- R3: xbit_mode_i selects the extra bit: 0 = none, 1 = even parity (the count of ones over data plus parity is even), 2 = odd parity, 3 = the value of mpb_i.
- R4: Every bit lasts exactly 16 baud_tick_i pulses. While a frame is in progress, txd_o changes only in a cycle where baud_tick_i is high. txd_o is a register output.
- R5: txd_o is 1 during and after reset and whenever no frame is in progress. A frame's start bit appears one cycle after the engine takes a byte from the idle state.
- R6: When the first stop bit begins, a queued byte (with tx_en_i=1) is taken at once. Its start bit follows the last stop bit in the next cycle, with no mark time between frames.
- R7: tx_end_o resets to 1. It is set when the first stop bit begins and no byte is taken then. It is cleared by clr_end_i or by any wr_en_i pulse, and the set wins over a clear in the same cycle.
- R8: empty_flag_o resets to 1. One cycle after the queue level is at or below trig_lvl_i, it reads 1. clr_empty_i clears it only while the level is above the trigger.
- R9: irq_o is high exactly when empty_flag_o and tx_en_i are both high.
- R10: The queue holds 16 bytes. A write while it holds 16 is dropped, even in a cycle where a byte leaves.
- R11: Writes are accepted while tx_en_i=0, but no byte leaves the queue then. A frame already started still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe into the queue |
| wr_data_i | input | 8 | Byte to queue |
| tx_en_i | input | 1 | Transmit enable |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| len7_i | input | 1 | 1 = 7 data bits, 0 = 8 |
| msb_first_i | input | 1 | 1 = MSB first |
| xbit_mode_i | input | 2 | Extra bit: 0 none, 1 even, 2 odd, 3 fixed value |
| mpb_i | input | 1 | Extra bit value in mode 3 |
| two_stop_i | input | 1 | 1 = two stop bits |
| trig_lvl_i | input | 5 | Low-water trigger level |
| clr_empty_i | input | 1 | Clear strobe for empty_flag_o |
| clr_end_i | input | 1 | Clear strobe for tx_end_o |
| txd_o | output | 1 | Serial line |
| empty_flag_o | output | 1 | Queue at or below trigger |
| tx_end_o | output | 1 | Transmission ended |
| irq_o | output | 1 | Low-water interrupt request |

## Verification
The assertions check several rules on every cycle. The line sits at mark when no frame is in progress, each frame opens with a 0, and txd_o holds still between ticks. Bytes leave only under enable, a full queue ignores writes, and the low-water flag follows the level. The bench's reference model covers what only scenarios can show: the exact bit sequence under each length, order, extra-bit and stop setting. It also covers the gapless handover at stop time, the drop of the seventeenth byte, the end flag's set and clear ordering, and the effect of pausing enable mid-stream.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FRM_W  = DATA_W + 2;  // start + data + extra bit
  localparam int unsigned NB_W   = $clog2(FRM_W + 1);

  typedef enum logic [1:0] {
    XB_NONE = 2'd0,
    XB_EVEN = 2'd1,
    XB_ODD  = 2'd2,
    XB_MPB  = 2'd3
  } xbit_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } eng_st_e;

  typedef struct packed {
    logic [FRM_W-1:0] bits;   // bit 0 goes out first
    logic [NB_W-1:0]  nbits;
  } frame_t;

  function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input logic len7,
                                         input logic msb, input xbit_e mode, input logic mpb);
    frame_t f;
    int unsigned dl;
    logic par;
    dl = len7 ? DATA_W - 1 : DATA_W;
    f.bits = '0;
    par = 1'b0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i < dl) begin
        f.bits[1+i] = msb ? d[dl-1-i] : d[i];
        par = par ^ d[i];
      end
    end
    f.nbits = NB_W'(1 + dl);
    case (mode)
      XB_EVEN: begin f.bits[1+dl] = par;  f.nbits = NB_W'(2 + dl); end
      XB_ODD:  begin f.bits[1+dl] = ~par; f.nbits = NB_W'(2 + dl); end
      XB_MPB:  begin f.bits[1+dl] = mpb;  f.nbits = NB_W'(2 + dl); end
      default: ;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          acc, take;

  assign acc  = push_i && (cnt_q < CW'(DEPTH));
  assign take = pop_i && (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (acc) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (acc)  wp_q <= nxt(wp_q);
      if (take) rp_q <= nxt(rp_q);
      case ({acc, take})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic             clr_empty_i,
  input  logic             clr_end_i,
  input  logic             wr_i,
  input  logic             end_set_i,
  input  logic             tx_en_i,
  output logic             empty_o,
  output logic             end_o,
  output logic             irq_o
);
  logic empty_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      if (cnt_i <= trig_i)  empty_q <= 1'b1;
      else if (clr_empty_i) empty_q <= 1'b0;
      if (end_set_i)               end_q <= 1'b1;
      else if (clr_end_i || wr_i)  end_q <= 1'b0;
    end
  end

  assign empty_o = empty_q;
  assign end_o   = end_q;
  assign irq_o   = empty_q && tx_en_i;
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  localparam int unsigned TW = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              len7_i,
  input  logic              msb_first_i,
  input  xbit_e             xmode_i,
  input  logic              mpb_i,
  input  logic              two_stop_i,
  output logic              pop_o,
  output logic              end_set_o,
  output logic              busy_o,
  output logic              txd_o
);
  eng_st_e          st_q;
  logic [TW-1:0]    tc_q;
  logic [FRM_W-1:0] frm_q;
  logic [NB_W-1:0]  left_q;
  logic [1:0]       stop_left_q;
  logic             stop2_q, next_q, txd_q;
  frame_t           nf;
  logic             bit_end, last_data, grab;

  assign nf        = build_frame(head_i, len7_i, msb_first_i, xmode_i, mpb_i);
  assign bit_end   = tick_i && (tc_q == TW'(OVS - 1));
  assign last_data = (st_q == ST_DATA) && bit_end && (left_q == NB_W'(1));
  assign grab      = tx_en_i && avail_i;
  assign pop_o     = grab && ((st_q == ST_IDLE) || last_data);
  assign end_set_o = last_data && !grab;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      tc_q        <= '0;
      frm_q       <= '0;
      left_q      <= '0;
      stop_left_q <= '0;
      stop2_q     <= 1'b0;
      next_q      <= 1'b0;
      txd_q       <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (grab) begin
            frm_q   <= nf.bits;
            left_q  <= nf.nbits;
            txd_q   <= nf.bits[0];
            tc_q    <= '0;
            stop2_q <= two_stop_i;
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (bit_end) begin
              tc_q <= '0;
              if (left_q == NB_W'(1)) begin
                // stop-bit time: sample the queue for the next frame
                st_q        <= ST_STOP;
                txd_q       <= 1'b1;
                stop_left_q <= stop2_q ? 2'd2 : 2'd1;
                next_q      <= grab;
                if (grab) begin
                  frm_q   <= nf.bits;
                  left_q  <= nf.nbits;
                  stop2_q <= two_stop_i;
                end
              end else begin
                frm_q  <= frm_q >> 1;
                txd_q  <= frm_q[1];
                left_q <= left_q - 1'b1;
              end
            end else begin
              tc_q <= tc_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (bit_end) begin
              tc_q <= '0;
              if (stop_left_q == 2'd1) begin
                if (next_q) begin
                  st_q  <= ST_DATA;
                  txd_q <= frm_q[0];
                end else begin
                  st_q  <= ST_IDLE;
                  txd_q <= 1'b1;
                end
              end else begin
                stop_left_q <= stop_left_q - 1'b1;
              end
            end else begin
              tc_q <= tc_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign txd_o  = txd_q;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OVS   = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              baud_tick_i,
  input  logic              len7_i,
  input  logic              msb_first_i,
  input  logic [1:0]        xbit_mode_i,
  input  logic              mpb_i,
  input  logic              two_stop_i,
  input  logic [CNT_W-1:0]  trig_lvl_i,
  input  logic              clr_empty_i,
  input  logic              clr_end_i,
  output logic              txd_o,
  output logic              empty_flag_o,
  output logic              tx_end_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              pop, end_set, busy;

  sertx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wr_en_i),
    .data_i (wr_data_i),
    .pop_i  (pop),
    .head_o (head),
    .cnt_o  (fifo_cnt)
  );

  sertx_engine #(.OVS(OVS)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .tx_en_i     (tx_en_i),
    .avail_i     (fifo_cnt != '0),
    .head_i      (head),
    .len7_i      (len7_i),
    .msb_first_i (msb_first_i),
    .xmode_i     (xbit_e'(xbit_mode_i)),
    .mpb_i       (mpb_i),
    .two_stop_i  (two_stop_i),
    .pop_o       (pop),
    .end_set_o   (end_set),
    .busy_o      (busy),
    .txd_o       (txd_o)
  );

  sertx_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (fifo_cnt),
    .trig_i      (trig_lvl_i),
    .clr_empty_i (clr_empty_i),
    .clr_end_i   (clr_end_i),
    .wr_i        (wr_en_i),
    .end_set_i   (end_set),
    .tx_en_i     (tx_en_i),
    .empty_o     (empty_flag_o),
    .end_o       (tx_end_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             tx_en_i,
  input logic             baud_tick_i,
  input logic [CNT_W-1:0] trig_lvl_i,
  input logic             txd_o,
  input logic             empty_flag_o,
  input logic             busy_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] cnt_i
);
  assert_mark_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o);

  assert_start_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !txd_o);

  assert_tick_paced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !baud_tick_i) |=> $stable(txd_o));

  assert_drain_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> tx_en_i);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(DEPTH) && wr_en_i && !pop_i) |=> (cnt_i == CNT_W'(DEPTH)));

  assert_low_water_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= trig_lvl_i) |=> empty_flag_o);
endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .tx_en_i      (tx_en_i),
  .baud_tick_i  (baud_tick_i),
  .trig_lvl_i   (trig_lvl_i),
  .txd_o        (txd_o),
  .empty_flag_o (empty_flag_o),
  .busy_i       (busy),
  .pop_i        (pop),
  .cnt_i        (fifo_cnt)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_en = 1'b0;
  logic       tick = 1'b0;
  logic       len7 = 1'b0, msb = 1'b0, mpb = 1'b0, two_stop = 1'b0;
  logic [1:0] xmode = 2'd0;
  logic [4:0] trig = 5'd4;
  logic       clr_empty = 1'b0, clr_end = 1'b0;
  logic       txd, empty_flag, tx_end, irq;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int tick_div = 1;
  int div_cnt = 0;

  sertx_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .baud_tick_i(tick), .len7_i(len7), .msb_first_i(msb),
    .xbit_mode_i(xmode), .mpb_i(mpb), .two_stop_i(two_stop), .trig_lvl_i(trig),
    .clr_empty_i(clr_empty), .clr_end_i(clr_end), .txd_o(txd),
    .empty_flag_o(empty_flag), .tx_end_o(tx_end), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    tick = (div_cnt == 0);
    div_cnt = (div_cnt + 1) % tick_div;
  end

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  bit  m_bits[$], m_next[$];
  bit  m_txd = 1'b1, m_empty = 1'b1, m_end = 1'b1;
  bit  m_have_next = 1'b0, m_stop2 = 1'b0;
  int  m_st = 0, m_tc = 0, m_stop_left = 0;

  function automatic logic [15:0] mk(input logic [7:0] d);
    int dl, n, ones;
    logic [11:0] v;
    dl = len7 ? 7 : 8;
    v = '0; n = 1; ones = 0;           // v[0] = start bit 0
    for (int i = 0; i < dl; i++) begin
      v[n] = msb ? d[dl-1-i] : d[i];
      ones += int'(d[i]);
      n++;
    end
    case (xmode)
      2'd1: begin v[n] = (ones % 2) != 0; n++; end
      2'd2: begin v[n] = (ones % 2) == 0; n++; end
      2'd3: begin v[n] = mpb; n++; end
      default: ;
    endcase
    return {4'(n), v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_bits.delete(); m_next.delete();
      m_txd = 1; m_empty = 1; m_end = 1; m_have_next = 0; m_stop2 = 0;
      m_st = 0; m_tc = 0; m_stop_left = 0;
    end else begin
      automatic int cnt = mq.size();
      automatic bit popped = 0;
      automatic bit end_set = 0;
      automatic logic [15:0] fv = mk((cnt > 0) ? mq[0] : 8'h00);
      case (m_st)
        0: if (tx_en && cnt > 0) begin
          m_bits.delete();
          for (int i = 0; i < int'(fv[15:12]); i++) m_bits.push_back(fv[i]);
          popped = 1; m_txd = m_bits.pop_front(); m_st = 1; m_tc = 0; m_stop2 = two_stop;
        end
        1: if (tick) begin
          if (m_tc == 15) begin
            m_tc = 0;
            if (m_bits.size() == 0) begin
              m_st = 2; m_stop_left = m_stop2 ? 2 : 1; m_txd = 1;
              if (tx_en && cnt > 0) begin
                m_next.delete();
                for (int i = 0; i < int'(fv[15:12]); i++) m_next.push_back(fv[i]);
                popped = 1; m_have_next = 1; m_stop2 = two_stop;
              end else begin
                m_have_next = 0; end_set = 1;
              end
            end else m_txd = m_bits.pop_front();
          end else m_tc++;
        end
        default: if (tick) begin
          if (m_tc == 15) begin
            m_tc = 0;
            if (m_stop_left == 1) begin
              if (m_have_next) begin
                m_bits = m_next; m_txd = m_bits.pop_front(); m_st = 1;
              end else begin
                m_st = 0; m_txd = 1;
              end
            end else m_stop_left--;
          end else m_tc++;
        end
      endcase
      if (cnt <= int'(trig)) m_empty = 1;
      else if (clr_empty)    m_empty = 0;
      if (end_set)                  m_end = 1;
      else if (clr_end || wr_en)    m_end = 0;
      if (popped) void'(mq.pop_front());
      if (wr_en && cnt < 16) mq.push_back(wr_data);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(txd == m_txd, "R1 R2 R3 R4 R5 R6 R10 R11 txd", txd, m_txd);
      chk(empty_flag == m_empty, "R8 empty_flag", empty_flag, m_empty);
      chk(tx_end == m_end, "R7 tx_end", tx_end, m_end);
      chk(irq == (m_empty && tx_en), "R9 irq", irq, m_empty && tx_en);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errs++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #2; wr_en = 1; wr_data = d;
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic pulse_clr(input bit e, input bit n);
    @(posedge clk); #2; clr_empty = e; clr_end = n;
    @(posedge clk); #2; clr_empty = 0; clr_end = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    // reset state: R5 R7 R8
    #(CLK_PERIOD*3);
    chk(txd == 1'b1, "R5 reset txd", txd, 1);
    chk(tx_end == 1'b1, "R7 reset tx_end", tx_end, 1);
    chk(empty_flag == 1'b1, "R8 reset empty_flag", empty_flag, 1);
    @(posedge clk); #2; rst_n = 1;

    // 8 bits, LSB first, no extra bit, one stop, back to back (R1 R2 R6)
    tx_en = 1; trig = 5'd1;
    wr(8'hA5); wr(8'h3C); wr(8'hFF);
    wait_cyc(300);
    pulse_clr(1, 1);            // clear strobes while busy (R7 R8)
    wait_cyc(500);

    // 7 bits, MSB first, even parity, two stops, slow ticks (R2 R3 R4)
    len7 = 1; msb = 1; xmode = 2'd1; two_stop = 1; tick_div = 3;
    wr(8'hD5); wr(8'h01);
    wait_cyc(1400);

    // 8 bits odd parity, then fixed extra bit (R3)
    len7 = 0; msb = 0; xmode = 2'd2; two_stop = 0; tick_div = 1; trig = 5'd0;
    wr(8'h00); wr(8'h80);
    wait_cyc(420);
    xmode = 2'd3; mpb = 1;
    wr(8'h7E);
    wait_cyc(100);
    mpb = 0;                     // taken at load: no effect on running frame
    wr(8'h81);
    wait_cyc(450);
    chk(txd == 1'b1 && tx_end == 1'b1, "R5 R7 idle after drain", {txd, tx_end}, 3);

    // queue while disabled, overflow by one (R10 R11)
    tx_en = 0; xmode = 2'd0; trig = 5'd8;
    for (int i = 0; i < 17; i++) wr(8'(i * 13 + 1));
    wait_cyc(40);
    chk(txd == 1'b1, "R11 no drain while disabled", txd, 1);
    pulse_clr(1, 1);             // level 16 > 8: clears (R8)
    wait_cyc(5);
    chk(empty_flag == 1'b0, "R8 clear above trigger", empty_flag, 0);
    tx_en = 1;
    wait_cyc(1000);
    tx_en = 0;                   // pause mid-stream (R11)
    wait_cyc(400);
    pulse_clr(1, 0);
    tx_en = 1;
    wait_cyc(2800);
    pulse_clr(1, 0);             // level 0 <= 8: stays set (R8)
    wait_cyc(5);
    chk(empty_flag == 1'b1, "R8 clear ignored at low level", empty_flag, 1);
    chk(txd == 1'b1, "R10 line idle after 16 frames", txd, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule